// File: doc/BRIEF.md
# Voice Group Trigger Controller

This block sits between a set of key or host inputs and an audio playback engine. It watches eight select lines, a dedicated step/strobe key and two mode pins. When a valid request appears it asks the engine to start a voice group, gives the group number, and tracks the playback until it ends. The block debounces every input over a selectable number of sample-clock ticks. It then applies the trigger options of the group concerned: edge or level sensing, holding, retriggering and an end-of-play pulse.

In key mode the select lines carry a key code that starts one of the low groups directly. The strobe key walks one group at a time through the upper groups. In parallel mode the select lines carry a full group address, and a strobe edge latches that address as a request. An external option store is looked up through an address output. It returns the four option bits of a group in the same cycle.

Top module: `vgrp_trigger_ctrl`

## Requirements
- R1: Mode pins 00 select key mode and 01 select parallel mode. With 10 or 11 no group is ever started.
- R2: Each select line and the strobe key is accepted only after its synchronised level has differed from the accepted level for DB_SHORT ticks of `tick_i` (`long_db_i`=0) or DB_LONG ticks (`long_db_i`=1). Any shorter excursion is discarded.
- R3: In key mode a debounced select code of 1 to 32 (select line 0 is the LSB) starts the group of that number when the code newly appears. Code 0 means no key, and codes 33 to 255 are ignored.
- R4: In key mode each strobe press starts the group held by a step pointer and then advances the pointer. The pointer is 33 after reset, counts up by one, and moves from 254 back to 33.
- R5: In parallel mode a strobe rising edge starts the group addressed by the select lines. Addresses 0 and 255 are ignored, and the step pointer is left unchanged.
- R6: The option word for the requested group is read from `opt_i` in the cycle when `opt_addr_o` shows that group. Its bits are: bit0 level sensing (1) or edge sensing (0), bit1 holdable, bit2 retriggerable, bit3 end pulse enabled.
- R7: While a group that is edge sensed and holdable plays, any new press ends it with `stop_o` and no new start.
- R8: While a retriggerable group plays (unless it is edge holdable), a new press starts the newly requested group at once.
- R9: While a group that is neither retriggerable nor edge holdable plays, a new press has no effect.
- R10: A level-sensed holdable group is stopped with `stop_o` as soon as its key or strobe is released. If `play_done_i` arrives while the key is still held, the same group is started again.
- R11: A group that is not both level sensed and holdable keeps playing after release until `play_done_i`.
- R12: When playback ends, through `play_done_i` or `stop_o`, `stop_pulse_o` rises for one cycle if bit3 of that group's options is set.
- R13: `start_o` and `stop_o` are single-cycle pulses and never occur together. `grp_o` shows the group being played. `busy_o` is high from a start until playback ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample-clock tick enable for debounce counting |
| mode_i | input | 2 | Trigger mode pins |
| sel_i | input | 8 | Select lines: key code or group address |
| seq_key_i | input | 1 | Step / strobe key |
| long_db_i | input | 1 | Chip-wide debounce length select |
| opt_i | input | 4 | Option word of the group on `opt_addr_o` |
| play_done_i | input | 1 | Playback engine finished the current group |
| opt_addr_o | output | 8 | Group whose options are looked up |
| start_o | output | 1 | Start request pulse |
| grp_o | output | 8 | Group number of the current playback |
| stop_o | output | 1 | Early stop request pulse |
| stop_pulse_o | output | 1 | End-of-play indication pulse |
| busy_o | output | 1 | Playback in progress |

## Verification
The checker assumes the playback engine raises `play_done_i` only while `busy_o` is high. It also assumes no finish report follows a stop the block has requested itself. The bench's player model respects both: it sends a finish pulse only after an observed start, and never after an expected stop. The checker also assumes the option store answers in the same cycle. The bench therefore derives `opt_i` combinationally from `opt_addr_o` through its own option table. Inputs change only on the falling clock edge. They stay stable for longer than the synchroniser and the debounce window, except in the deliberate glitch case, so each press maps to exactly one expected event.

// File: rtl/vgt_pkg.sv
package vgt_pkg;

    localparam int GRP_W = 8;
    localparam logic [GRP_W-1:0] DIRECT_LAST = 8'd32;
    localparam logic [GRP_W-1:0] SEQ_FIRST   = 8'd33;
    localparam logic [GRP_W-1:0] GRP_LAST    = 8'd254;
    localparam logic [GRP_W-1:0] GRP_NONE    = 8'd0;
    localparam logic [GRP_W-1:0] GRP_BAD     = 8'd255;

    localparam logic [1:0] MODE_KEY = 2'b00;
    localparam logic [1:0] MODE_PAR = 2'b01;

    // bit3 end pulse, bit2 retrigger, bit1 hold, bit0 level sense
    typedef struct packed {
        logic end_pulse;
        logic retrig;
        logic hold;
        logic level;
    } grp_opt_t;

    typedef struct packed {
        logic             valid;
        logic             from_strobe;
        logic [GRP_W-1:0] grp;
    } press_t;

    typedef enum logic {
        ST_IDLE,
        ST_PLAY
    } play_st_t;

    function automatic logic [GRP_W-1:0] step_next(input logic [GRP_W-1:0] cur);
        return (cur >= GRP_LAST) ? SEQ_FIRST : cur + 8'd1;
    endfunction

endpackage

// File: rtl/vgt_debounce.sv
module vgt_debounce #(
    parameter int DB_SHORT = 1,
    parameter int DB_LONG  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic long_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(DB_LONG + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = long_i ? CW'(DB_LONG) : CW'(DB_SHORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= 1'b0;
            cnt     <= '0;
        end else if (raw_i == level_o) begin
            cnt <= '0;
        end else if (tick_i) begin
            if (cnt >= lim - CW'(1)) begin
                level_o <= raw_i;
                cnt     <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/vgt_input_stage.sv
module vgt_input_stage #(
    parameter int N_IN     = 9,
    parameter int SYNC_LEN = 2,
    parameter int DB_SHORT = 1,
    parameter int DB_LONG  = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            long_i,
    input  logic [N_IN-1:0] raw_i,
    output logic [N_IN-1:0] clean_o
);
    logic [N_IN-1:0] sync_q [SYNC_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_LEN; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= raw_i;
            for (int s = 1; s < SYNC_LEN; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_line
        vgt_debounce #(
            .DB_SHORT(DB_SHORT),
            .DB_LONG (DB_LONG)
        ) u_db (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_i),
            .long_i (long_i),
            .raw_i  (sync_q[SYNC_LEN-1][i]),
            .level_o(clean_o[i])
        );
    end
endmodule

// File: rtl/vgt_req_decode.sv
module vgt_req_decode
    import vgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [GRP_W-1:0] sel_i,
    input  logic             strobe_i,
    output press_t           press_o,
    output logic [GRP_W-1:0] step_ptr_o
);
    logic [GRP_W-1:0] prev_code;
    logic             prev_strobe;
    logic             key_mode, par_mode;
    logic             code_ok, key_press, strobe_rise, step_press, par_press;

    assign key_mode    = (mode_i == MODE_KEY);
    assign par_mode    = (mode_i == MODE_PAR);
    assign code_ok     = (sel_i != GRP_NONE) && (sel_i <= DIRECT_LAST);
    assign key_press   = key_mode && code_ok && (sel_i != prev_code);
    assign strobe_rise = strobe_i && !prev_strobe;
    assign step_press  = key_mode && strobe_rise && !key_press;
    assign par_press   = par_mode && strobe_rise &&
                         (sel_i != GRP_NONE) && (sel_i != GRP_BAD);

    always_comb begin
        press_o = '0;
        if (key_press) begin
            press_o.valid = 1'b1;
            press_o.grp   = sel_i;
        end else if (step_press) begin
            press_o.valid       = 1'b1;
            press_o.from_strobe = 1'b1;
            press_o.grp         = step_ptr_o;
        end else if (par_press) begin
            press_o.valid       = 1'b1;
            press_o.from_strobe = 1'b1;
            press_o.grp         = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_code   <= GRP_NONE;
            prev_strobe <= 1'b0;
            step_ptr_o  <= SEQ_FIRST;
        end else begin
            prev_code   <= sel_i;
            prev_strobe <= strobe_i;
            if (step_press) step_ptr_o <= step_next(step_ptr_o);
        end
    end
endmodule

// File: rtl/vgt_play_fsm.sv
module vgt_play_fsm
    import vgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  press_t           press_i,
    input  grp_opt_t         opt_i,
    input  logic [GRP_W-1:0] sel_i,
    input  logic             strobe_i,
    input  logic             done_i,
    output logic             start_o,
    output logic             stop_o,
    output logic             end_pulse_o,
    output logic [GRP_W-1:0] grp_o,
    output logic             busy_o
);
    play_st_t st_q, st_d;
    grp_opt_t opt_q, opt_d;
    logic     src_q, src_d;
    logic [GRP_W-1:0] grp_d;
    logic     start_d, stop_d, end_d;
    logic     held, edge_hold, level_hold;

    assign held       = src_q ? strobe_i : (sel_i == grp_o);
    assign edge_hold  = !opt_q.level && opt_q.hold;
    assign level_hold = opt_q.level && opt_q.hold;
    assign busy_o     = (st_q == ST_PLAY);

    always_comb begin
        st_d    = st_q;
        opt_d   = opt_q;
        src_d   = src_q;
        grp_d   = grp_o;
        start_d = 1'b0;
        stop_d  = 1'b0;
        end_d   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (press_i.valid) begin
                    st_d    = ST_PLAY;
                    opt_d   = opt_i;
                    src_d   = press_i.from_strobe;
                    grp_d   = press_i.grp;
                    start_d = 1'b1;
                end
            end
            ST_PLAY: begin
                if (press_i.valid && edge_hold) begin
                    st_d   = ST_IDLE;
                    stop_d = 1'b1;
                    end_d  = opt_q.end_pulse;
                end else if (press_i.valid && opt_q.retrig) begin
                    opt_d   = opt_i;
                    src_d   = press_i.from_strobe;
                    grp_d   = press_i.grp;
                    start_d = 1'b1;
                end else if (level_hold && !held) begin
                    st_d   = ST_IDLE;
                    stop_d = 1'b1;
                    end_d  = opt_q.end_pulse;
                end else if (done_i) begin
                    if (level_hold) begin
                        start_d = 1'b1;
                    end else begin
                        st_d  = ST_IDLE;
                        end_d = opt_q.end_pulse;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            opt_q       <= '0;
            src_q       <= 1'b0;
            grp_o       <= GRP_NONE;
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            end_pulse_o <= 1'b0;
        end else begin
            st_q        <= st_d;
            opt_q       <= opt_d;
            src_q       <= src_d;
            grp_o       <= grp_d;
            start_o     <= start_d;
            stop_o      <= stop_d;
            end_pulse_o <= end_d;
        end
    end
endmodule

// File: rtl/vgrp_trigger_ctrl.sv
module vgrp_trigger_ctrl
    import vgt_pkg::*;
#(
    parameter int DB_SHORT = 1,
    parameter int DB_LONG  = 128,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic [GRP_W-1:0] sel_i,
    input  logic             seq_key_i,
    input  logic             long_db_i,
    input  logic [3:0]       opt_i,
    input  logic             play_done_i,
    output logic [GRP_W-1:0] opt_addr_o,
    output logic             start_o,
    output logic [GRP_W-1:0] grp_o,
    output logic             stop_o,
    output logic             stop_pulse_o,
    output logic             busy_o
);
    localparam int N_IN = GRP_W + 1;

    logic [N_IN-1:0]  clean;
    logic [GRP_W-1:0] sel_db;
    logic             strobe_db;
    press_t           press;
    logic [GRP_W-1:0] step_ptr;

    vgt_input_stage #(
        .N_IN    (N_IN),
        .SYNC_LEN(SYNC_LEN),
        .DB_SHORT(DB_SHORT),
        .DB_LONG (DB_LONG)
    ) u_in (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .long_i (long_db_i),
        .raw_i  ({seq_key_i, sel_i}),
        .clean_o(clean)
    );

    assign sel_db    = clean[GRP_W-1:0];
    assign strobe_db = clean[GRP_W];

    vgt_req_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .sel_i     (sel_db),
        .strobe_i  (strobe_db),
        .press_o   (press),
        .step_ptr_o(step_ptr)
    );

    assign opt_addr_o = press.grp;

    vgt_play_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .press_i    (press),
        .opt_i      (grp_opt_t'(opt_i)),
        .sel_i      (sel_db),
        .strobe_i   (strobe_db),
        .done_i     (play_done_i),
        .start_o    (start_o),
        .stop_o     (stop_o),
        .end_pulse_o(stop_pulse_o),
        .grp_o      (grp_o),
        .busy_o     (busy_o)
    );
endmodule

// File: rtl/vgt_checker.sv
module vgt_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_o,
    input logic       stop_o,
    input logic       stop_pulse_o,
    input logic       busy_o,
    input logic [7:0] grp_o,
    input logic       play_done_i,
    input logic [7:0] step_ptr
);
    // R13
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);
    // R13
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> start_o);
    // R13
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));
    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !busy_o);
    // R12
    end_pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_pulse_o |-> !busy_o);
    // R12
    end_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        stop_pulse_o |=> !stop_pulse_o);
    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (step_ptr >= 8'd33) && (step_ptr <= 8'd254));
    // R3
    grp_range_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ((grp_o != 8'd0) && (grp_o != 8'd255)));
    // R11
    done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        play_done_i |-> busy_o);
endmodule

bind vgrp_trigger_ctrl vgt_checker u_vgt_chk (
    .clk         (clk),
    .rst         (rst),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .stop_pulse_o(stop_pulse_o),
    .busy_o      (busy_o),
    .grp_o       (grp_o),
    .play_done_i (play_done_i),
    .step_ptr    (step_ptr)
);

// File: tb/test_vgrp_trigger_ctrl.sv
module test_vgrp_trigger_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic [7:0] sel_i = 8'd0;
    logic       seq_key_i = 1'b0;
    logic       long_db_i = 1'b0;
    logic [3:0] opt_i;
    logic       play_done_i = 1'b0;
    logic [7:0] opt_addr_o;
    logic       start_o;
    logic [7:0] grp_o;
    logic       stop_o;
    logic       stop_pulse_o;
    logic       busy_o;

    localparam int EV_START = 0;
    localparam int EV_STOP  = 1;
    localparam int EV_PULSE = 2;

    typedef struct {
        int         kind;
        logic [7:0] grp;
        string      req;
    } ev_t;

    ev_t        exp_q[$];
    logic [3:0] opt_mem [256];
    int         n_run  = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    assign opt_i = opt_mem[opt_addr_o];

    vgrp_trigger_ctrl i_vgrp_trigger_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .mode_i(mode_i), .sel_i(sel_i),
        .seq_key_i(seq_key_i), .long_db_i(long_db_i), .opt_i(opt_i),
        .play_done_i(play_done_i), .opt_addr_o(opt_addr_o), .start_o(start_o),
        .grp_o(grp_o), .stop_o(stop_o), .stop_pulse_o(stop_pulse_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [7:0] grp, input string req);
        ev_t e;
        e.kind = kind;
        e.grp  = grp;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic see_ev(input int kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R13 unexpected event", kind, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind && e.grp == grp_o, e.req,
                kind * 1000 + int'(grp_o), e.kind * 1000 + int'(e.grp));
        end
    endtask

    // Monitor: compares observed pulses against the expected queue
    always @(negedge clk) begin
        if (!rst) begin
            if (start_o)      see_ev(EV_START);
            if (stop_o)       see_ev(EV_STOP);
            if (stop_pulse_o) see_ev(EV_PULSE);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(input logic [7:0] v);
        @(negedge clk);
        sel_i = v;
        wait_cyc(8);
    endtask

    task automatic tap_strobe();
        @(negedge clk);
        seq_key_i = 1'b1;
        wait_cyc(8);
        seq_key_i = 1'b0;
        wait_cyc(8);
    endtask

    task automatic finish_play();
        @(negedge clk);
        play_done_i = 1'b1;
        @(negedge clk);
        play_done_i = 1'b0;
        wait_cyc(3);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) opt_mem[i] = 4'b0000;
        opt_mem[5]  = 4'b1000;
        opt_mem[9]  = 4'b0100;
        opt_mem[3]  = 4'b1011;
        opt_mem[4]  = 4'b0001;
        opt_mem[6]  = 4'b0010;

        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R13 reset state
        chk(busy_o == 1'b0, "R13 reset busy", busy_o, 0);
        chk(start_o == 1'b0 && stop_o == 1'b0 && stop_pulse_o == 1'b0,
            "R13 reset pulses", start_o, 0);

        // R3 direct key start, R9 ignored press, R12 end pulse on finish
        expect_ev(EV_START, 8'd5, "R3 key code 5 start");
        set_sel(8'd5);
        chk(busy_o == 1'b1, "R3 busy after key", busy_o, 1);
        set_sel(8'd0);
        set_sel(8'd7);
        set_sel(8'd0);
        chk(busy_o == 1'b1, "R9 press ignored busy", busy_o, 1);
        drained("R9 no event on ignored press");
        expect_ev(EV_PULSE, 8'd5, "R12 end pulse after finish");
        finish_play();
        chk(busy_o == 1'b0, "R12 idle after finish", busy_o, 0);

        // R8 retrigger to another group
        expect_ev(EV_START, 8'd9, "R8 first start");
        set_sel(8'd9);
        set_sel(8'd0);
        expect_ev(EV_START, 8'd12, "R8 retrigger start");
        set_sel(8'd12);
        set_sel(8'd0);
        finish_play();
        chk(busy_o == 1'b0, "R8 idle after finish", busy_o, 0);
        drained("R8 events");

        // R10 level holdable, R6 option bits read per group
        expect_ev(EV_START, 8'd3, "R6 level hold start");
        set_sel(8'd3);
        expect_ev(EV_START, 8'd3, "R10 restart while held");
        finish_play();
        chk(busy_o == 1'b1, "R10 busy while held", busy_o, 1);
        expect_ev(EV_STOP, 8'd3, "R10 stop on release");
        expect_ev(EV_PULSE, 8'd3, "R12 end pulse on stop");
        set_sel(8'd0);
        chk(busy_o == 1'b0, "R10 idle after release", busy_o, 0);

        // R11 level unholdable keeps playing after release
        expect_ev(EV_START, 8'd4, "R11 start");
        set_sel(8'd4);
        set_sel(8'd0);
        chk(busy_o == 1'b1, "R11 busy after release", busy_o, 1);
        finish_play();
        chk(busy_o == 1'b0, "R11 idle after finish", busy_o, 0);

        // R7 edge holdable stopped by a new press
        expect_ev(EV_START, 8'd6, "R7 start");
        set_sel(8'd6);
        set_sel(8'd0);
        expect_ev(EV_STOP, 8'd6, "R7 stop on second press");
        set_sel(8'd6);
        set_sel(8'd0);
        chk(busy_o == 1'b0, "R7 idle after stop", busy_o, 0);

        // R3 codes above the direct range are ignored
        set_sel(8'd40);
        chk(busy_o == 1'b0, "R3 code 40 ignored", busy_o, 0);
        set_sel(8'd0);
        drained("R3 no event for high code");

        // R4 step key walks 33..254 then wraps
        for (int g = 33; g <= 254; g++) begin
            expect_ev(EV_START, 8'(g), "R4 step start");
            tap_strobe();
            finish_play();
        end
        expect_ev(EV_START, 8'd33, "R4 wrap to 33");
        tap_strobe();
        finish_play();
        drained("R4 step events");

        // R5 parallel address, R1 keys inert in parallel mode
        @(negedge clk);
        mode_i = 2'b01;
        set_sel(8'd5);
        chk(busy_o == 1'b0, "R1 key code inert in parallel mode", busy_o, 0);
        set_sel(8'd200);
        expect_ev(EV_START, 8'd200, "R5 parallel start");
        tap_strobe();
        finish_play();
        set_sel(8'd0);
        tap_strobe();
        chk(busy_o == 1'b0, "R5 address 0 ignored", busy_o, 0);
        set_sel(8'd255);
        tap_strobe();
        chk(busy_o == 1'b0, "R5 address 255 ignored", busy_o, 0);
        set_sel(8'd0);
        drained("R5 parallel events");

        // R1 invalid mode starts nothing
        @(negedge clk);
        mode_i = 2'b10;
        set_sel(8'd5);
        tap_strobe();
        chk(busy_o == 1'b0, "R1 mode 10 inert", busy_o, 0);
        set_sel(8'd0);
        @(negedge clk);
        mode_i = 2'b00;
        wait_cyc(4);
        drained("R1 no events");

        // R2 long debounce: glitch dropped, stable press accepted late
        @(negedge clk);
        long_db_i = 1'b1;
        wait_cyc(4);
        @(negedge clk);
        sel_i = 8'd5;
        wait_cyc(50);
        sel_i = 8'd0;
        wait_cyc(200);
        chk(busy_o == 1'b0, "R2 short glitch rejected", busy_o, 0);
        drained("R2 no event for glitch");
        expect_ev(EV_START, 8'd5, "R2 long debounce start");
        @(negedge clk);
        sel_i = 8'd5;
        wait_cyc(100);
        chk(busy_o == 1'b0, "R2 not accepted early", busy_o, 0);
        wait_cyc(60);
        chk(busy_o == 1'b1, "R2 accepted after window", busy_o, 1);
        sel_i = 8'd0;
        wait_cyc(200);
        expect_ev(EV_PULSE, 8'd5, "R12 end pulse long mode");
        finish_play();
        chk(busy_o == 1'b0, "R2 idle at end", busy_o, 0);
        drained("R13 all expected events seen");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R13 watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule